// File: doc/BRIEF.md
# SPI Sensor Command Slave

This block is the serial front end of a two-channel sensor. A host selects the device by pulling the active-low chip select low and then clocks in an 8-bit command, most significant bit first. Depending on the command, the block either shifts a channel sample or a status byte out on MISO, or collects one write byte that follows the command with no gap and hands it to a control register through a one-cycle strobe.

The serial pins are oversampled in the block's own clock domain. Each of SCK, MOSI and chip select passes through a synchronizer, and the edges of SCK and chip select are detected there. MOSI is taken on the SCK rising edge. MISO changes on the SCK falling edge and is qualified by an output-enable, so a pad can tri-state it. A command that matches no known code locks the interface silent until the next selection. Raising chip select abandons any transfer at once.

Top module: `spi_sensor_slave`

## Requirements
- R1: After reset, and at any time chip select is high, `miso_oe` is 0 and `wr_stb` is 0.
- R2: The 8 MOSI bits taken on the first 8 SCK rising edges after a chip-select falling edge form the command, MSB first. Command 8'h10 returns the 11-bit X sample on MISO, MSB first.
- R3: Command 8'h11 returns the 11-bit Y sample. Command 8'h20 returns the 8-bit status word. Both are sent MSB first.
- R4: For a read, `miso_oe` rises and MISO carries the first data bit on the first SCK falling edge after the rising edge that took the last command bit. Before that, `miso_oe` is 0.
- R5: On the SCK falling edge after the last data bit of a read, `miso_oe` returns to 0. Further SCK edges in that selection leave it at 0.
- R6: The read word is captured when the command decodes. Changes on the sample or status inputs during the read do not alter the bits sent.
- R7: Command 8'h40 takes the next 8 MOSI bits, MSB first, as a write byte. After the 8th bit, `wr_stb` pulses high for exactly one clock with the byte on `wr_data`. Further bits in that selection produce no strobe.
- R8: Command 8'h00 is a no-op. Any code other than 8'h00, 8'h10, 8'h11, 8'h20 and 8'h40 is invalid. After either, `miso_oe` stays 0 and no strobe occurs until the next chip-select falling edge, even if later bits spell a valid command. The next selection decodes normally.
- R9: A chip-select rising edge in the middle of a command or a write ends the transfer with no strobe. It clears the bit count and the partial command, so the next selection decodes a fresh command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| csb | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| sample_x | input | 11 | Parallel X-channel sample |
| sample_y | input | 11 | Parallel Y-channel sample |
| status | input | 8 | Parallel status word |
| miso | output | 1 | Serial data to the host, valid when miso_oe is 1 |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| wr_stb | output | 1 | One-clock strobe for the write byte |
| wr_data | output | 8 | Write byte, valid with wr_stb |

## Verification
Each of the three reads is run with a distinct data pattern, so that swapped channels, a dropped bit or a reversed bit order shows up on MISO. The first X read is clocked past its last bit, and its sample inputs are flipped mid-read; this separates a correct release and a latched word from a late enable or a live data path. Writes are run with exactly eight data bits and with sixteen. An invalid code is followed by bits that spell a valid write; this tells a true lock apart from a decoder that restarts. Aborts during the command and during the write data, each followed by a fresh read, show whether the counter and the command register are cleared.

// File: rtl/spi_sensor_pkg.sv
package spi_sensor_pkg;

    localparam int CMD_W    = 8;
    localparam int SAMPLE_W = 11;
    localparam int STAT_W   = 8;
    localparam int WR_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_WRITE,
        ST_DONE,
        ST_LOCK
    } link_state_e;

    typedef enum logic [2:0] {
        OP_RD_X,
        OP_RD_Y,
        OP_RD_ST,
        OP_WR,
        OP_NOP,
        OP_BAD
    } link_op_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_fall;
        logic cs_on;
        logic mosi;
    } pin_evt_t;

    function automatic link_op_e decode_op(
        input logic [CMD_W-1:0] code,
        input logic [CMD_W-1:0] c_rdx,
        input logic [CMD_W-1:0] c_rdy,
        input logic [CMD_W-1:0] c_rst,
        input logic [CMD_W-1:0] c_wr,
        input logic [CMD_W-1:0] c_nop
    );
        if (code == c_rdx) return OP_RD_X;
        if (code == c_rdy) return OP_RD_Y;
        if (code == c_rst) return OP_RD_ST;
        if (code == c_wr)  return OP_WR;
        if (code == c_nop) return OP_NOP;
        return OP_BAD;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_sensor_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     csb,
    input  logic     mosi,
    output pin_evt_t evt
);
    // bit 2 = sck, bit 1 = csb, bit 0 = mosi
    localparam logic [2:0] PIPE_RST = 3'b010;

    logic [2:0] pipe [STAGES];
    logic       sck_d;
    logic       csb_d;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= PIPE_RST;
        else     pipe[0] <= {sck, csb, mosi};
    end

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) pipe[k] <= PIPE_RST;
                else     pipe[k] <= pipe[k-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            csb_d <= 1'b1;
        end else begin
            sck_d <= pipe[STAGES-1][2];
            csb_d <= pipe[STAGES-1][1];
        end
    end

    always_comb begin
        evt.rise    =  pipe[STAGES-1][2] & ~sck_d;
        evt.fall    = ~pipe[STAGES-1][2] &  sck_d;
        evt.cs_fall = ~pipe[STAGES-1][1] &  csb_d;
        evt.cs_on   = ~pipe[STAGES-1][1];
        evt.mosi    =  pipe[STAGES-1][0];
    end

endmodule

// File: rtl/spi_link_ctrl.sv
module spi_link_ctrl
    import spi_sensor_pkg::*;
#(
    parameter int               SMP_W  = SAMPLE_W,
    parameter int               ST_W   = STAT_W,
    parameter int               W_W    = WR_W,
    parameter logic [CMD_W-1:0] C_RDX  = 8'h10,
    parameter logic [CMD_W-1:0] C_RDY  = 8'h11,
    parameter logic [CMD_W-1:0] C_RST  = 8'h20,
    parameter logic [CMD_W-1:0] C_WR   = 8'h40,
    parameter logic [CMD_W-1:0] C_NOP  = 8'h00
) (
    input  logic             clk,
    input  logic             rst,
    input  pin_evt_t         evt,
    input  logic [SMP_W-1:0] sample_x,
    input  logic [SMP_W-1:0] sample_y,
    input  logic [ST_W-1:0]  status,
    output logic             miso,
    output logic             miso_oe,
    output logic             wr_stb,
    output logic [W_W-1:0]   wr_data
);
    localparam int OUT_W = (SMP_W > ST_W) ? SMP_W : ST_W;
    localparam int MAX_N = (OUT_W > CMD_W) ? ((OUT_W > W_W) ? OUT_W : W_W)
                                           : ((CMD_W > W_W) ? CMD_W : W_W);
    localparam int CNT_W = $clog2(MAX_N + 1);

    link_state_e      state;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rem_q;
    logic [CMD_W-2:0] cmd_part_q;
    logic [W_W-2:0]   wpart_q;
    logic [OUT_W-1:0] sh_q;
    logic [CMD_W-1:0] cmd_next;
    link_op_e         op;

    always_comb begin
        cmd_next = {cmd_part_q, evt.mosi};
        op       = decode_op(cmd_next, C_RDX, C_RDY, C_RST, C_WR, C_NOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt_q      <= '0;
            rem_q      <= '0;
            cmd_part_q <= '0;
            wpart_q    <= '0;
            sh_q       <= '0;
            miso       <= 1'b0;
            miso_oe    <= 1'b0;
            wr_stb     <= 1'b0;
            wr_data    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (!evt.cs_on) begin
                state      <= ST_IDLE;
                cnt_q      <= '0;
                cmd_part_q <= '0;
                miso       <= 1'b0;
                miso_oe    <= 1'b0;
            end else if (evt.cs_fall) begin
                state      <= ST_CMD;
                cnt_q      <= '0;
                cmd_part_q <= '0;
                miso_oe    <= 1'b0;
            end else begin
                case (state)
                    ST_CMD: if (evt.rise) begin
                        cmd_part_q <= cmd_next[CMD_W-2:0];
                        if (cnt_q == CNT_W'(CMD_W - 1)) begin
                            cnt_q <= '0;
                            case (op)
                                OP_RD_X: begin
                                    sh_q  <= OUT_W'(sample_x) << (OUT_W - SMP_W);
                                    rem_q <= CNT_W'(SMP_W);
                                    state <= ST_READ;
                                end
                                OP_RD_Y: begin
                                    sh_q  <= OUT_W'(sample_y) << (OUT_W - SMP_W);
                                    rem_q <= CNT_W'(SMP_W);
                                    state <= ST_READ;
                                end
                                OP_RD_ST: begin
                                    sh_q  <= OUT_W'(status) << (OUT_W - ST_W);
                                    rem_q <= CNT_W'(ST_W);
                                    state <= ST_READ;
                                end
                                OP_WR:   state <= ST_WRITE;
                                OP_NOP:  state <= ST_DONE;
                                default: state <= ST_LOCK;
                            endcase
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_READ: if (evt.fall) begin
                        if (rem_q != '0) begin
                            miso    <= sh_q[OUT_W-1];
                            sh_q    <= sh_q << 1;
                            miso_oe <= 1'b1;
                            rem_q   <= rem_q - 1'b1;
                        end else begin
                            miso    <= 1'b0;
                            miso_oe <= 1'b0;
                            state   <= ST_DONE;
                        end
                    end
                    ST_WRITE: if (evt.rise) begin
                        wpart_q <= {wpart_q[W_W-3:0], evt.mosi};
                        if (cnt_q == CNT_W'(W_W - 1)) begin
                            wr_stb  <= 1'b1;
                            wr_data <= {wpart_q, evt.mosi};
                            cnt_q   <= '0;
                            state   <= ST_DONE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> state == ST_READ);                                 // R4
    AST_OE_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(miso_oe) |-> $past(evt.fall) && $past(state) == ST_READ); // R4
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);                                           // R7
    AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_stb) |-> $past(state) == ST_WRITE && state == ST_DONE); // R7
    AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (rst)
        state == ST_LOCK |-> !miso_oe && !wr_stb);                     // R8
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !evt.cs_on |=> !miso_oe && state == ST_IDLE && cnt_q == '0);   // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(MAX_N));                                        // R2

endmodule

// File: rtl/spi_sensor_slave.sv
module spi_sensor_slave
    import spi_sensor_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter int               SMP_W       = SAMPLE_W,
    parameter int               ST_W        = STAT_W,
    parameter int               W_W         = WR_W,
    parameter logic [CMD_W-1:0] CODE_RD_X   = 8'h10,
    parameter logic [CMD_W-1:0] CODE_RD_Y   = 8'h11,
    parameter logic [CMD_W-1:0] CODE_RD_ST  = 8'h20,
    parameter logic [CMD_W-1:0] CODE_WR     = 8'h40,
    parameter logic [CMD_W-1:0] CODE_NOP    = 8'h00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck,
    input  logic             csb,
    input  logic             mosi,
    input  logic [SMP_W-1:0] sample_x,
    input  logic [SMP_W-1:0] sample_y,
    input  logic [ST_W-1:0]  status,
    output logic             miso,
    output logic             miso_oe,
    output logic             wr_stb,
    output logic [W_W-1:0]   wr_data
);
    pin_evt_t evt;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sck  (sck),
        .csb  (csb),
        .mosi (mosi),
        .evt  (evt)
    );

    spi_link_ctrl #(
        .SMP_W (SMP_W),
        .ST_W  (ST_W),
        .W_W   (W_W),
        .C_RDX (CODE_RD_X),
        .C_RDY (CODE_RD_Y),
        .C_RST (CODE_RD_ST),
        .C_WR  (CODE_WR),
        .C_NOP (CODE_NOP)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sample_x (sample_x),
        .sample_y (sample_y),
        .status   (status),
        .miso     (miso),
        .miso_oe  (miso_oe),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data)
    );

endmodule

// File: tb/tb_spi_sensor_slave.sv
module tb_spi_sensor_slave;

    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        csb = 1'b1;
    logic        mosi = 1'b0;
    logic [10:0] sample_x = '0;
    logic [10:0] sample_y = '0;
    logic [7:0]  status = '0;
    logic        miso;
    logic        miso_oe;
    logic        wr_stb;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_err = 0;
    int stb_cnt = 0;
    logic [7:0] stb_data = '0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_sensor_slave dut (
        .clk(clk), .rst(rst), .sck(sck), .csb(csb), .mosi(mosi),
        .sample_x(sample_x), .sample_y(sample_y), .status(status),
        .miso(miso), .miso_oe(miso_oe), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    // strobe reference: count pulses and keep the last byte
    always @(posedge clk) begin
        if (!rst && wr_stb) begin
            stb_cnt  <= stb_cnt + 1;
            stb_data <= wr_data;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one selection: ncmd command bits, then npay payload bits (MSB of pay first)
    task automatic txn(input logic [7:0] cmd, input int ncmd,
                       input logic [15:0] pay, input int npay,
                       input int rd_len, input logic [10:0] rd_word,
                       input bit flip, input string req);
        int f;
        logic exp_oe, exp_d;
        csb = 1'b0;
        tick(H);
        for (int i = 0; i < ncmd + npay; i++) begin
            mosi = (i < ncmd) ? cmd[7-i] : pay[15-(i-ncmd)];
            tick(H);
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
            tick(H/2);
            f = i + 1 - 7;
            exp_oe = (ncmd == 8) && (rd_len > 0) && (f >= 1) && (f <= rd_len);
            exp_d  = exp_oe ? rd_word[rd_len-f] : 1'b0;
            chk({req, " oe"}, 32'(miso_oe), 32'(exp_oe));
            if (exp_oe) chk({req, " data"}, 32'(miso), 32'(exp_d));
            if (flip && i == 9) begin
                sample_x = ~sample_x;
                sample_y = ~sample_y;
                status   = ~status;
            end
            tick(H/2);
        end
        tick(H);
        csb = 1'b1;
        tick(H);
        chk({req, " deselect oe"}, 32'(miso_oe), 32'd0);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R1 reset oe", 32'(miso_oe), 32'd0);
        chk("R1 reset stb", 32'(wr_stb), 32'd0);

        // R2 R4 R5 R6: X read, clocked past the end, inputs flipped mid-read
        sample_x = 11'h5A3; sample_y = 11'h2C6; status = 8'hB4;
        txn(8'h10, 8, 16'h0000, 14, 11, 11'h5A3, 1'b1, "R2/R4/R5/R6 read X");
        sample_x = 11'h5A3; sample_y = 11'h2C6; status = 8'hB4;

        txn(8'h11, 8, 16'hFFFF, 11, 11, 11'h2C6, 1'b0, "R3 read Y");
        txn(8'h20, 8, 16'h0000, 10, 8, 11'h0B4, 1'b0, "R3 read status");

        begin
            int s0;
            s0 = stb_cnt;
            txn(8'h40, 8, 16'hA700, 8, 0, 11'h0, 1'b0, "R7 write");
            chk("R7 strobe count", 32'(stb_cnt - s0), 32'd1);
            chk("R7 write byte", 32'(stb_data), 32'hA7);

            s0 = stb_cnt;
            txn(8'h40, 8, 16'h3CFF, 16, 0, 11'h0, 1'b0, "R7 write extra bits");
            chk("R7 single strobe", 32'(stb_cnt - s0), 32'd1);
            chk("R7 first byte kept", 32'(stb_data), 32'h3C);

            s0 = stb_cnt;
            txn(8'hFF, 8, 16'h4055, 16, 0, 11'h0, 1'b0, "R8 invalid lock");
            chk("R8 no strobe after invalid", 32'(stb_cnt - s0), 32'd0);
            txn(8'h10, 8, 16'h0000, 12, 11, 11'h5A3, 1'b0, "R8 recover read");

            s0 = stb_cnt;
            txn(8'h00, 8, 16'h4055, 16, 0, 11'h0, 1'b0, "R8 no-op");
            chk("R8 no strobe after no-op", 32'(stb_cnt - s0), 32'd0);

            s0 = stb_cnt;
            txn(8'h40, 8, 16'h5000, 4, 0, 11'h0, 1'b0, "R9 abort write");
            chk("R9 no strobe on abort", 32'(stb_cnt - s0), 32'd0);
            txn(8'h11, 8, 16'h0000, 12, 11, 11'h2C6, 1'b0, "R9 read after abort");

            txn(8'hE0, 3, 16'h0000, 0, 0, 11'h0, 1'b0, "R9 abort command");
            txn(8'h20, 8, 16'h0000, 9, 8, 11'h0B4, 1'b0, "R9 fresh decode");
            chk("R9 no stray strobe", 32'(stb_cnt - s0), 32'd0);
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule